// File: doc/BRIEF.md
# Per-Channel Fault Status Latch with Low-Side Deglitch

This block gathers the fault flags of a twelve-output power switch and keeps a sticky status word for a serial host to read. Channels 0 to 3 are high-side drivers and channels 4 to 11 are low-side drivers. Each channel reports overtemperature and open load. The low-side channels also report overcurrent. A single overvoltage flag covers the whole device. Any accepted fault sets that channel's status bit to 1, and the bit stays set until the host has read it.

The low-side channels carry a deglitch counter. Overcurrent counts only while the channel is commanded on, and open load counts only while it is commanded off. A flag must stay asserted for `FILT_CYCLES` consecutive clock edges before it is accepted. The count restarts whenever the flag drops or the channel's command changes. High-side faults, overtemperature on any channel, and overvoltage need no such persistence: they latch on the first edge at which they are seen.

The host reads the word while chip select (`cs_n`, active low) is asserted. On the rising edge of chip select, every bit whose fault has gone away clears. A bit whose fault is still present stays set.

Top module: `chan_fault_status`

## Requirements
- R1: After reset, and after any later reset, `status_word` is all zeros.
- R2: A high-side channel (status bits 0 to 3) sets its bit at the first clock edge that samples its `ot_flag` or `ol_flag` bit high.
- R3: Overtemperature on a low-side channel sets its bit at the first clock edge that samples it, with no filtering.
- R4: Overcurrent on a low-side channel that is on sets its bit only after `oc_flag` has been high on `FILT_CYCLES` consecutive edges. A shorter burst leaves the bit at 0.
- R5: Open load on a low-side channel that is off is filtered in the same way as R4. Open load while the channel is on is ignored, and so is overcurrent while the channel is off.
- R6: A change of a low-side channel's `ch_on` bit restarts its filter. Counting begins at the edge after the change, so a fault already present needs `FILT_CYCLES`+1 edges to latch.
- R7: A set status bit stays set until a rising edge of `cs_n` at which its fault is absent. The bit reads 0 after that edge.
- R8: A status bit whose fault is present at the `cs_n` rising edge stays set.
- R9: The overvoltage flag latches into `status_word[12]` at the first edge that samples it, and clears under the same rule as R7 and R8.
- R10: Bit k of `status_word` belongs to channel k. Channels 0 to 3 are high-side and 4 to 11 are low-side. `oc_flag[j]` belongs to channel 4+j, and `ot_flag`, `ol_flag` and `ch_on` are indexed by channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Serial chip select, active low; its rising edge clears inactive faults |
| ch_on | input | 12 | Commanded on state per channel |
| ot_flag | input | 12 | Raw overtemperature flag per channel |
| ol_flag | input | 12 | Raw open-load flag per channel |
| oc_flag | input | 8 | Raw overcurrent flag per low-side channel (channel 4+j) |
| ov_flag | input | 1 | Raw global overvoltage flag |
| status_word | output | 13 | Latched fault bits: [11:0] per channel, [12] overvoltage |

## Verification
Two kinds of internal error reach the ports quickly. A corrupted filter count shows up as a low-side bit that rises one or more edges early or late against the `FILT_CYCLES` boundary. A broken chip-select edge detector shows up as a bit that fails to drop, or drops without a frame, on the edge after `cs_n` rises. The bench therefore samples directly on both sides of each boundary: one edge short of the filter limit and exactly at it, with and without a command change, and right after a chip-select rising edge with the fault present and with it absent. Because bits are sticky, a stray set at any point stays visible in every later check until the next clearing edge.

// File: rtl/chfs_pkg.sv
package chfs_pkg;

    localparam int unsigned HS_CH_DEF   = 4;
    localparam int unsigned LS_CH_DEF   = 8;
    localparam int unsigned FILT_DEF    = 16;

    // width of a counter that must hold values 0 .. n-1
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/chfs_cs_edge.sv
module chfs_cs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic rise_o
);

    typedef struct packed {
        logic cs_prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.cs_prev = cs_n;
        rise_o       = cs_n & ~st_q.cs_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cs_prev: 1'b1};
        else        st_q <= st_d;
    end

    // R7
    rise_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/chfs_ls_filter.sv
module chfs_ls_filter #(
    parameter int unsigned FILT_CYCLES = chfs_pkg::FILT_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on_i,
    input  logic ot_i,
    input  logic oc_i,
    input  logic ol_i,
    output logic accept_o,
    output logic present_o
);

    localparam int unsigned CW = chfs_pkg::cnt_width(FILT_CYCLES);
    localparam logic [CW-1:0] TERM = CW'(FILT_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] oc_cnt;
        logic [CW-1:0] ol_cnt;
        logic          on_prev;
    } filt_st_t;

    filt_st_t st_d, st_q;
    logic     changed;
    logic     oc_cond, ol_cond;
    logic     oc_hit, ol_hit;

    always_comb begin
        st_d         = st_q;
        changed      = on_i ^ st_q.on_prev;
        oc_cond      = on_i & oc_i & ~changed;
        ol_cond      = ~on_i & ol_i & ~changed;
        oc_hit       = oc_cond && (st_q.oc_cnt == TERM);
        ol_hit       = ol_cond && (st_q.ol_cnt == TERM);

        st_d.on_prev = on_i;

        if (!oc_cond)    st_d.oc_cnt = '0;
        else if (oc_hit) st_d.oc_cnt = TERM;
        else             st_d.oc_cnt = st_q.oc_cnt + 1'b1;

        if (!ol_cond)    st_d.ol_cnt = '0;
        else if (ol_hit) st_d.ol_cnt = TERM;
        else             st_d.ol_cnt = st_q.ol_cnt + 1'b1;

        accept_o  = ot_i | oc_hit | ol_hit;
        present_o = ot_i | (on_i & oc_i) | (~on_i & ol_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    if (FILT_CYCLES > 1) begin : g_chk
        // R4
        oc_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
            oc_hit |-> $past(on_i && oc_i));
        // R5
        ol_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ol_hit |-> $past(!on_i && ol_i));
        // R6
        restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (on_i != st_q.on_prev) |=> !(oc_hit || ol_hit));
    end

endmodule

// File: rtl/chfs_status_reg.sv
module chfs_status_reg #(
    parameter int unsigned W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] present_i,
    input  logic         clr_i,
    output logic [W-1:0] status_o
);

    typedef struct packed {
        logic [W-1:0] bits;
    } stat_st_t;

    stat_st_t     st_d, st_q;
    logic [W-1:0] drop;

    always_comb begin
        st_d      = st_q;
        drop      = {W{clr_i}} & ~present_i;
        st_d.bits = set_i | (st_q.bits & ~drop);
        status_o  = st_q.bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (($past(status_o) & ~status_o) == '0));
    // R2
    set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((status_o & $past(set_i)) == $past(set_i)));
    // R8
    keep_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((status_o & ($past(status_o) & $past(present_i)))
                   == ($past(status_o) & $past(present_i))));
    // R7
    clear_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((status_o & ~$past(present_i) & ~$past(set_i)) == '0));

endmodule

// File: rtl/chan_fault_status.sv
module chan_fault_status #(
    parameter int unsigned N_HS        = chfs_pkg::HS_CH_DEF,
    parameter int unsigned N_LS        = chfs_pkg::LS_CH_DEF,
    parameter int unsigned FILT_CYCLES = chfs_pkg::FILT_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic [N_HS+N_LS-1:0] ch_on,
    input  logic [N_HS+N_LS-1:0] ot_flag,
    input  logic [N_HS+N_LS-1:0] ol_flag,
    input  logic [N_LS-1:0]      oc_flag,
    input  logic                 ov_flag,
    output logic [N_HS+N_LS:0]   status_word
);

    localparam int unsigned NCH = N_HS + N_LS;
    localparam int unsigned SW  = NCH + 1;

    logic [SW-1:0] set_v;
    logic [SW-1:0] present_v;
    logic          cs_rise;

    chfs_cs_edge u_cs_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .rise_o (cs_rise)
    );

    for (genvar h = 0; h < N_HS; h++) begin : g_hs
        assign set_v[h]     = ot_flag[h] | ol_flag[h];
        assign present_v[h] = ot_flag[h] | ol_flag[h];

        // R2
        hs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ot_flag[h] || ol_flag[h]) |=> status_word[h]);
    end

    for (genvar l = 0; l < N_LS; l++) begin : g_ls
        localparam int unsigned CH = N_HS + l;

        chfs_ls_filter #(
            .FILT_CYCLES (FILT_CYCLES)
        ) u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .on_i      (ch_on[CH]),
            .ot_i      (ot_flag[CH]),
            .oc_i      (oc_flag[l]),
            .ol_i      (ol_flag[CH]),
            .accept_o  (set_v[CH]),
            .present_o (present_v[CH])
        );

        // R3
        ls_ot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ot_flag[CH] |=> status_word[CH]);
    end

    assign set_v[NCH]     = ov_flag;
    assign present_v[NCH] = ov_flag;

    chfs_status_reg #(
        .W (SW)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_v),
        .present_i (present_v),
        .clr_i     (cs_rise),
        .status_o  (status_word)
    );

    // R9
    ov_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ov_flag |=> status_word[NCH]);

endmodule

// File: tb/chan_fault_status_tb_top.sv
`timescale 1ns/1ps
module chan_fault_status_tb_top;

    localparam int unsigned FILT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic [11:0] ch_on = 12'h0F0;
    logic [11:0] ot_flag = '0;
    logic [11:0] ol_flag = '0;
    logic [7:0]  oc_flag = '0;
    logic        ov_flag = 1'b0;
    logic [12:0] status_word;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    chan_fault_status #(
        .N_HS        (4),
        .N_LS        (8),
        .FILT_CYCLES (FILT)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .ch_on       (ch_on),
        .ot_flag     (ot_flag),
        .ol_flag     (ol_flag),
        .oc_flag     (oc_flag),
        .ov_flag     (ov_flag),
        .status_word (status_word)
    );

    typedef struct packed {
        logic [11:0] ot;
        logic [11:0] ol;
        logic [7:0]  oc;
        logic        ov;
        logic [3:0]  hold;
        logic        cs;
        logic [12:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    // ch_on = 0x0F0: channels 4..7 on, 8..11 off
    localparam vec_t VECS [NV] = '{
        '{12'h000, 12'h000, 8'h00, 1'b0, 4'd3, 1'b0, 13'h0000, 4'd1},  // R1 idle
        '{12'h001, 12'h000, 8'h00, 1'b0, 4'd1, 1'b0, 13'h0001, 4'd2},  // R2 ot ch0
        '{12'h000, 12'h000, 8'h00, 1'b0, 4'd2, 1'b0, 13'h0001, 4'd7},  // R7 sticky
        '{12'h000, 12'h000, 8'h00, 1'b0, 4'd1, 1'b1, 13'h0000, 4'd7},  // R7 clear
        '{12'h000, 12'h004, 8'h00, 1'b0, 4'd1, 1'b0, 13'h0004, 4'd2},  // R2 ol ch2
        '{12'h000, 12'h004, 8'h00, 1'b0, 4'd1, 1'b1, 13'h0004, 4'd8},  // R8 kept
        '{12'h000, 12'h000, 8'h00, 1'b0, 4'd1, 1'b1, 13'h0000, 4'd7},  // R7
        '{12'h000, 12'h000, 8'h01, 1'b0, 4'd4, 1'b0, 13'h0000, 4'd4},  // R4 short
        '{12'h000, 12'h000, 8'h00, 1'b0, 4'd1, 1'b0, 13'h0000, 4'd4},  // R4 gap
        '{12'h000, 12'h000, 8'h01, 1'b0, 4'd5, 1'b0, 13'h0010, 4'd4},  // R4 full
        '{12'h000, 12'h000, 8'h00, 1'b0, 4'd1, 1'b1, 13'h0000, 4'd7},  // R7
        '{12'h000, 12'h000, 8'h10, 1'b0, 4'd8, 1'b0, 13'h0000, 4'd5},  // R5 oc off
        '{12'h000, 12'h100, 8'h00, 1'b0, 4'd5, 1'b0, 13'h0100, 4'd5},  // R5 ol off
        '{12'h000, 12'h020, 8'h00, 1'b0, 4'd8, 1'b0, 13'h0100, 4'd5},  // R5 ol on
        '{12'h000, 12'h000, 8'h00, 1'b0, 4'd1, 1'b1, 13'h0000, 4'd7},  // R7
        '{12'h800, 12'h000, 8'h00, 1'b0, 4'd1, 1'b0, 13'h0800, 4'd3},  // R3 ot ch11
        '{12'h000, 12'h000, 8'h00, 1'b1, 4'd1, 1'b0, 13'h1800, 4'd9},  // R9 ov
        '{12'h000, 12'h000, 8'h00, 1'b0, 4'd1, 1'b1, 13'h0000, 4'd9},  // R9 clear
        '{12'h000, 12'h000, 8'h08, 1'b0, 4'd5, 1'b0, 13'h0080, 4'd10}, // R10 oc[3]->ch7
        '{12'h000, 12'h000, 8'h00, 1'b0, 4'd1, 1'b1, 13'h0000, 4'd10}  // R10
    };

    task automatic check(input logic [12:0] exp, input string tag);
        n_chk++;
        if (status_word !== exp) begin
            n_bad++;
            $display("FAIL %s: status_word=%h expected=%h", tag, status_word, exp);
        end
    endtask

    task automatic cs_pulse();
        cs_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_edges(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        wait_edges(3);
        rst_n = 1'b1;
        @(negedge clk);
        check(13'h0000, "R1 after reset");

        for (int v = 0; v < NV; v++) begin
            ot_flag = VECS[v].ot;
            ol_flag = VECS[v].ol;
            oc_flag = VECS[v].oc;
            ov_flag = VECS[v].ov;
            wait_edges(int'(VECS[v].hold));
            if (VECS[v].cs) cs_pulse();
            check(VECS[v].exp, $sformatf("R%0d vector %0d", VECS[v].req, v));
        end

        // R5: open load on ch8 while it is on is ignored
        ot_flag = '0; oc_flag = '0; ov_flag = 1'b0;
        ch_on[8] = 1'b1;
        ol_flag  = 12'h100;
        wait_edges(3);
        check(13'h0000, "R5 ol while on");

        // R6: turning ch8 off restarts the count, needs FILT+1 edges
        ch_on[8] = 1'b0;
        wait_edges(FILT);
        check(13'h0000, "R6 one edge short");
        wait_edges(1);
        check(13'h0100, "R6 latched");

        ol_flag = '0;
        cs_pulse();
        check(13'h0000, "R7 clear after R6");

        // R1: a mid-run reset clears latched bits
        ot_flag = 12'h002;
        wait_edges(1);
        check(13'h0002, "R2 ot ch1");
        ot_flag = '0;
        rst_n = 1'b0;
        wait_edges(1);
        rst_n = 1'b1;
        wait_edges(1);
        check(13'h0000, "R1 mid-run reset");

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: done=0 expected=1");
            finish_run();
        end
    end

endmodule